// File: doc/BRIEF.md
# Cache-Line Split Request Generator

This block sits between a load/store issue stage and a line-based memory port. It takes one access at a time, described by a byte address, a byte count, a load/store flag and a tag. It then issues that access as a stream of fragments. No fragment ever spans two cache lines. The line size is a power-of-two parameter.

An access that fits inside one line comes out unchanged as a single fragment. An access that crosses a boundary is cut into three kinds of fragment:

- a partial head, running from the start address up to the next line boundary;
- any number of whole, aligned lines;
- a partial tail, present only when bytes are still left after the whole lines.

Each fragment carries its own address and byte count. It also carries its byte position inside the original data buffer, a running index, and a flag that marks the final fragment. The downstream side pulls fragments over a valid/ready handshake, one per cycle. The input stays closed until the current access has drained. A request for zero bytes produces no fragments and is answered with a one-cycle error pulse.

Top module: `lsplit_gen`

## Requirements
- R1: While reset is held and immediately after it, `frag_valid` and `req_err` are low and `req_ready` is high.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low until the handshake of the final fragment, and it is high again on the cycle after that. Requests offered while `req_ready` is low have no effect on the fragment stream.
- R3: An access whose in-line offset (address modulo line size) plus its size is not greater than the line size gives exactly one fragment. That fragment has the request's address and size, index 0, offset 0 and `frag_last` set.
- R4: For an access that crosses a boundary, the first fragment starts at the request address. Its size is the line size minus the in-line offset.
- R5: Fragments between the head and the tail are exactly one line long and start at line-aligned addresses.
- R6: A tail fragment is issued only if bytes remain after the whole lines. The final fragment ends exactly at address plus size, and no fragment has size 0.
- R7: `frag_offset` equals the sum of the sizes of all earlier fragments of the same request. `frag_index` counts up from 0. `frag_last` is high on the final fragment only.
- R8: Fragments of one request come out in ascending, contiguous address order, with address arithmetic modulo 2^ADDR_W. Each fragment starts at the previous fragment's address plus its size.
- R9: While `frag_valid` is high and `frag_ready` is low, every fragment output holds its value into the next cycle.
- R10: A request with size 0 is taken, gives no fragment, and raises `req_err` for exactly the cycle after it is taken. `req_ready` stays high.
- R11: Every fragment repeats the `req_store` flag and `req_id` of the request it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | SIZE_W | Byte count of the access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_id | input | ID_W | Tag of the access |
| req_err | output | 1 | One-cycle pulse: zero-size request rejected |
| frag_valid | output | 1 | Fragment present |
| frag_ready | input | 1 | Consumer takes the fragment |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_size | output | $clog2(LINE_BYTES)+1 | Fragment byte count |
| frag_offset | output | SIZE_W | Byte position inside the original buffer |
| frag_index | output | IDX_W | Fragment number, from 0 |
| frag_last | output | 1 | Final fragment of the access |
| frag_store | output | 1 | Copy of the request's store flag |
| frag_id | output | ID_W | Copy of the request's tag |

## Verification
The bench checks the two sides of the split test. An access that ends exactly on a line boundary must stay whole; a design that uses greater-or-equal instead of strictly-greater would emit an empty or wrongly sized extra fragment there. One byte further must split into a 4+1 pair.

It also checks accesses with several kinds of shape:

- Aligned whole-line multiples. A design that forces a tail would add a zero-length fragment.
- A start on the last byte of a line. Head handling that is off by one would produce the wrong head size.
- An access that wraps the top of the address space.
- The largest possible size, which has 64 fragments and tests the index width.

Further directed cases cover the rest:

- Stalls on the consumer side, where the outputs must not move.
- Requests pushed while busy, which a leaky input gate would splice into the stream.
- A zero-size request, which must raise the error pulse and emit nothing.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

   // Largest fragment count a request of size_w bits can produce on a given line.
   function automatic int lsp_frag_max(input int size_w, input int line_bytes);
      return ((1 << size_w) - 1) / line_bytes + 2;
   endfunction

   function automatic bit lsp_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lsplit_chunk.sv
// Size of the next fragment: the smaller of the bytes left and the room left in the line.
module lsplit_chunk #(
   parameter int SIZE_W     = 12,
   parameter int LINE_BYTES = 64,
   localparam int LB        = $clog2(LINE_BYTES),
   localparam int OFF_W     = (LB > 0) ? LB : 1,
   localparam int CH_W      = LB + 1,
   localparam int CMP_W     = (SIZE_W > CH_W) ? SIZE_W : CH_W
) (
   input  logic [OFF_W-1:0]  line_off,
   input  logic [SIZE_W-1:0] remain,
   output logic [CH_W-1:0]   chunk,
   output logic              fits
);
   logic [CMP_W-1:0] room_w;
   logic [CMP_W-1:0] rem_w;

   generate
      if (LB == 0) begin : g_byte_line
         logic unused_off;
         assign unused_off = line_off[0];
         assign room_w     = CMP_W'(1);
      end else begin : g_wide_line
         assign room_w = CMP_W'(LINE_BYTES) - CMP_W'(line_off);
      end
   endgenerate

   assign rem_w = CMP_W'(remain);
   assign fits  = (rem_w <= room_w);
   assign chunk = fits ? CH_W'(rem_w) : CH_W'(room_w);
endmodule

// File: rtl/lsplit_intake.sv
// Input gate: takes a request only when idle, filters zero-size requests.
module lsplit_intake #(
   parameter int SIZE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              req_valid,
   input  logic [SIZE_W-1:0] req_size,
   output logic              req_ready,
   output logic              load,
   output logic              req_err
);
   logic accept;
   logic zero_len;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign zero_len  = (req_size == '0);
   assign load      = accept && !zero_len;

   always_ff @(posedge clk) begin
      if (!rst_n) req_err <= 1'b0;
      else        req_err <= accept && zero_len;
   end
endmodule

// File: rtl/lsplit_walker.sv
// Holds the request in flight and steps through its fragments.
module lsplit_walker #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 12,
   parameter int ID_W   = 4,
   parameter int CH_W   = 7,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [SIZE_W-1:0] ld_size,
   input  logic              ld_store,
   input  logic [ID_W-1:0]   ld_id,
   input  logic              step,
   input  logic [CH_W-1:0]   chunk,
   input  logic              fits,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [SIZE_W-1:0] remain,
   output logic [SIZE_W-1:0] offset,
   output logic [IDX_W-1:0]  index,
   output logic              store,
   output logic [ID_W-1:0]   id
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
         offset   <= '0;
         index    <= '0;
         store    <= 1'b0;
         id       <= '0;
      end else if (load) begin
         busy     <= 1'b1;
         cur_addr <= ld_addr;
         remain   <= ld_size;
         offset   <= '0;
         index    <= '0;
         store    <= ld_store;
         id       <= ld_id;
      end else if (step) begin
         cur_addr <= cur_addr + ADDR_W'(chunk);
         remain   <= remain - SIZE_W'(chunk);
         offset   <= offset + SIZE_W'(chunk);
         index    <= index + IDX_W'(1);
         if (fits) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/lsplit_gen.sv
module lsplit_gen #(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 12,
   parameter int ID_W       = 4,
   parameter int LINE_BYTES = 64,
   localparam int LB        = $clog2(LINE_BYTES),
   localparam int OFF_W     = (LB > 0) ? LB : 1,
   localparam int CH_W      = LB + 1,
   localparam int FRAG_MAX  = lsplit_pkg::lsp_frag_max(SIZE_W, LINE_BYTES),
   localparam int IDX_W     = $clog2(FRAG_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_store,
   input  logic [ID_W-1:0]   req_id,
   output logic              req_err,
   output logic              frag_valid,
   input  logic              frag_ready,
   output logic [ADDR_W-1:0] frag_addr,
   output logic [CH_W-1:0]   frag_size,
   output logic [SIZE_W-1:0] frag_offset,
   output logic [IDX_W-1:0]  frag_index,
   output logic              frag_last,
   output logic              frag_store,
   output logic [ID_W-1:0]   frag_id
);
   generate
      if (!lsplit_pkg::lsp_is_pow2(LINE_BYTES)) begin : g_bad_line
         initial $error("lsplit_gen: LINE_BYTES must be a power of two");
      end
      if (ADDR_W < LB + 1) begin : g_bad_addr
         initial $error("lsplit_gen: ADDR_W too narrow for LINE_BYTES");
      end
      if (SIZE_W < 1 || ID_W < 1) begin : g_bad_width
         initial $error("lsplit_gen: SIZE_W and ID_W must be positive");
      end
   endgenerate

   logic              busy;
   logic              load;
   logic              step;
   logic              fits;
   logic [CH_W-1:0]   chunk;
   logic [SIZE_W-1:0] remain;

   lsplit_intake #(.SIZE_W(SIZE_W)) u_intake (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .req_valid (req_valid),
      .req_size  (req_size),
      .req_ready (req_ready),
      .load      (load),
      .req_err   (req_err)
   );

   lsplit_chunk #(.SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)) u_chunk (
      .line_off (frag_addr[OFF_W-1:0]),
      .remain   (remain),
      .chunk    (chunk),
      .fits     (fits)
   );

   assign step = busy && frag_ready;

   lsplit_walker #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W),
      .ID_W   (ID_W),
      .CH_W   (CH_W),
      .IDX_W  (IDX_W)
   ) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .ld_addr  (req_addr),
      .ld_size  (req_size),
      .ld_store (req_store),
      .ld_id    (req_id),
      .step     (step),
      .chunk    (chunk),
      .fits     (fits),
      .busy     (busy),
      .cur_addr (frag_addr),
      .remain   (remain),
      .offset   (frag_offset),
      .index    (frag_index),
      .store    (frag_store),
      .id       (frag_id)
   );

   assign frag_valid = busy;
   assign frag_size  = chunk;
   assign frag_last  = fits;
endmodule

// File: rtl/lsplit_gen_chk.sv
module lsplit_gen_chk #(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 12,
   parameter int ID_W       = 4,
   parameter int LINE_BYTES = 64,
   localparam int CH_W      = $clog2(LINE_BYTES) + 1,
   localparam int IDX_W     = $clog2(lsplit_pkg::lsp_frag_max(SIZE_W, LINE_BYTES))
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [SIZE_W-1:0] req_size,
   input logic              req_store,
   input logic [ID_W-1:0]   req_id,
   input logic              req_err,
   input logic              frag_valid,
   input logic              frag_ready,
   input logic [ADDR_W-1:0] frag_addr,
   input logic [CH_W-1:0]   frag_size,
   input logic [SIZE_W-1:0] frag_offset,
   input logic [IDX_W-1:0]  frag_index,
   input logic              frag_last,
   input logic              frag_store,
   input logic [ID_W-1:0]   frag_id
);
   logic take_req;
   assign take_req = req_valid && req_ready;

   p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take_req && (req_size != '0) |=> frag_valid && !req_ready);

   p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frag_valid && frag_ready && frag_last |=> req_ready && !frag_valid);

   p_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_req && (req_size != '0) |=> (frag_index == '0) && (frag_offset == '0)
         && (frag_addr == $past(req_addr)) && (frag_id == $past(req_id))
         && (frag_store == $past(req_store)));

   p_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frag_valid && frag_ready && !frag_last |=> frag_valid
         && (frag_addr == $past(frag_addr) + ADDR_W'($past(frag_size)))
         && (frag_offset == $past(frag_offset) + SIZE_W'($past(frag_size)))
         && (frag_index == $past(frag_index) + IDX_W'(1)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frag_valid && !frag_ready |=> frag_valid && $stable(frag_addr)
         && $stable(frag_size) && $stable(frag_offset) && $stable(frag_index)
         && $stable(frag_last) && $stable(frag_store) && $stable(frag_id));

   p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frag_valid |-> (32'(frag_addr % ADDR_W'(LINE_BYTES)) + 32'(frag_size))
         <= 32'(LINE_BYTES));

   p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frag_valid |-> (frag_size != '0));

   p_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_req && (req_size == '0) |=> req_err && !frag_valid && req_ready);
endmodule

bind lsplit_gen lsplit_gen_chk #(
   .ADDR_W     (ADDR_W),
   .SIZE_W     (SIZE_W),
   .ID_W       (ID_W),
   .LINE_BYTES (LINE_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_addr    (req_addr),
   .req_size    (req_size),
   .req_store   (req_store),
   .req_id      (req_id),
   .req_err     (req_err),
   .frag_valid  (frag_valid),
   .frag_ready  (frag_ready),
   .frag_addr   (frag_addr),
   .frag_size   (frag_size),
   .frag_offset (frag_offset),
   .frag_index  (frag_index),
   .frag_last   (frag_last),
   .frag_store  (frag_store),
   .frag_id     (frag_id)
);

// File: tb/lsplit_gen_test.sv
module lsplit_gen_test;
   localparam int L  = 64;
   localparam int NV = 11;

   localparam logic [31:0] V_ADDR [NV] = '{32'h0000_0100, 32'h0000_013C, 32'h0000_013C,
      32'h0000_1000, 32'h0000_1001, 32'h0000_1030, 32'h0000_2000, 32'h0000_203F,
      32'h0000_203F, 32'hFFFF_FFF0, 32'h0000_3000};
   localparam int V_SIZE [NV] = '{8, 4, 5, 64, 64, 200, 256, 1, 130, 32, 4095};
   localparam int V_CNT  [NV] = '{1, 1, 2, 1, 2, 4, 4, 1, 4, 2, 64};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [11:0] req_size = '0;
   logic        req_store = 1'b0;
   logic [3:0]  req_id = '0;
   logic        req_err;
   logic        frag_valid;
   logic        frag_ready = 1'b1;
   logic [31:0] frag_addr;
   logic [6:0]  frag_size;
   logic [11:0] frag_offset;
   logic [6:0]  frag_index;
   logic        frag_last;
   logic        frag_store;
   logic [3:0]  frag_id;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   lsplit_gen uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_store(req_store), .req_id(req_id),
      .req_err(req_err), .frag_valid(frag_valid), .frag_ready(frag_ready),
      .frag_addr(frag_addr), .frag_size(frag_size), .frag_offset(frag_offset),
      .frag_index(frag_index), .frag_last(frag_last), .frag_store(frag_store),
      .frag_id(frag_id)
   );

   task automatic chk(input bit ok, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic run_req(input logic [31:0] a, input int sz, input bit st,
                          input logic [3:0] tag, input int cnt, input bit bp,
                          input bit noise);
      logic [31:0] maddr;
      int mrem, moff, idx, esz, room;
      bit elast, done;
      logic [31:0] h_addr;
      logic [6:0]  h_size;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = 12'(sz); req_store = st; req_id = tag;
      @(negedge clk);
      if (noise) begin
         req_addr = 32'hDEAD_0000; req_size = 12'd8; req_store = !st; req_id = ~tag;
      end else req_valid = 1'b0;
      chk(req_ready == 1'b0, "R2 ready low while busy", 64'(req_ready), 64'd0);
      maddr = a; mrem = sz; moff = 0; idx = 0; done = 0;
      while (!done && idx < 100) begin
         room  = L - int'(maddr % L);
         esz   = (mrem < room) ? mrem : room;
         elast = (esz == mrem);
         chk(frag_valid == 1'b1, "R2 fragment present", 64'(frag_valid), 64'd1);
         chk(frag_addr == maddr, (idx == 0) ? "R4 head address" : "R8 fragment address",
             64'(frag_addr), 64'(maddr));
         chk(int'(frag_size) == esz,
             (cnt == 1) ? "R3 single size" : (idx == 0) ? "R4 head size" :
             elast ? "R6 tail size" : "R5 full line size", 64'(frag_size), 64'(esz));
         chk(int'(frag_offset) == moff, "R7 buffer offset", 64'(frag_offset), 64'(moff));
         chk(int'(frag_index) == idx, "R7 index", 64'(frag_index), 64'(idx));
         chk(frag_last == elast, "R7 last flag", 64'(frag_last), 64'(elast));
         chk(frag_store == st && frag_id == tag, "R11 store flag and id",
             64'({frag_store, frag_id}), 64'({st, tag}));
         if (noise && elast) req_valid = 1'b0;
         if (bp && (idx % 2 == 0)) begin
            h_addr = frag_addr; h_size = frag_size;
            frag_ready = 1'b0;
            @(negedge clk);
            chk(frag_valid && frag_addr == h_addr && frag_size == h_size &&
                int'(frag_offset) == moff && int'(frag_index) == idx,
                "R9 held under stall", 64'({frag_addr, frag_size}), 64'({h_addr, h_size}));
            frag_ready = 1'b1;
         end
         @(negedge clk);
         maddr = maddr + 32'(esz); mrem = mrem - esz; moff = moff + esz; idx++;
         done = elast;
      end
      chk(idx == cnt, "R6 fragment count", 64'(idx), 64'(cnt));
      chk(frag_valid == 1'b0 && req_ready == 1'b1, "R2 idle after final fragment",
          64'({frag_valid, req_ready}), 64'b01);
      chk(maddr == a + 32'(sz), "R6 end address", 64'(maddr), 64'(a + 32'(sz)));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(frag_valid == 1'b0 && req_ready == 1'b1 && req_err == 1'b0,
          "R1 reset state", 64'({frag_valid, req_ready, req_err}), 64'b010);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frag_valid == 1'b0 && req_ready == 1'b1 && req_err == 1'b0,
          "R1 state after reset", 64'({frag_valid, req_ready, req_err}), 64'b010);

      for (int i = 0; i < NV; i++)
         run_req(V_ADDR[i], V_SIZE[i], i[0], 4'(i), V_CNT[i], (i % 3) == 1, 1'b0);

      // R2: requests pushed while busy must not disturb the stream
      run_req(32'h0000_0040, 130, 1'b1, 4'hA, 3, 1'b0, 1'b1);
      @(negedge clk);
      chk(frag_valid == 1'b0, "R2 no fragment from ignored request", 64'(frag_valid), 64'd0);

      // R10: zero-size request
      req_valid = 1'b1; req_addr = 32'h0000_0500; req_size = 12'd0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_err == 1'b1, "R10 error pulse", 64'(req_err), 64'd1);
      chk(frag_valid == 1'b0 && req_ready == 1'b1, "R10 no fragment, still ready",
          64'({frag_valid, req_ready}), 64'b01);
      @(negedge clk);
      chk(req_err == 1'b0, "R10 pulse one cycle", 64'(req_err), 64'd0);
      chk(frag_valid == 1'b0, "R10 nothing emitted later", 64'(frag_valid), 64'd0);

      // R3: boundary-exact access after an error, under stall
      run_req(32'h0000_07C0, 64, 1'b0, 4'h3, 1, 1'b1, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule